// File: doc/BRIEF.md
# Write-DMA Frame Control Sequencer

This block is the control sequencer of a display write-DMA engine that stores one clipped frame into memory. After a frame-start strobe with the engine enabled, it walks through a clear phase and two prepare phases and then accepts pixels. Each pixel-valid strobe advances a raster position across a source image of programmable width and height. Only pixels inside a programmable clip window are forwarded. When the last pixel of the window is accepted, the sequencer waits for the memory side to acknowledge end of frame. It then reports end-of-frame done and frame complete, and returns to idle.

A soft-reset input pulls the sequencer out of any active phase through a reset-wait and a reset-done phase to idle. While the input stays high, the sequencer is held in idle. Software starts a soft reset, polls the idle flag, and then releases the input. Three interrupt status bits latch events through an enable mask and are cleared by writing ones. The block also exposes the current input line and the number of pixels accepted in the frame.

Top module: `wdma_frame_seq`

## Requirements
- R1: `status` is one-hot at all times, with these codes: 0x001 idle, 0x002 clear, 0x004 prepare A, 0x008 prepare B, 0x010 running, 0x020 end-of-frame wait, 0x040 soft-reset wait, 0x080 end-of-frame done, 0x100 soft-reset done, 0x200 frame complete. `idle` is high exactly when status is 0x001; reset leaves status 0x001, counters 0 and interrupt bits 0.
- R2: In idle, with `soft_rst` low, `enable` and `frame_start` high for one cycle move status to clear, prepare A, prepare B and running on the following four cycles. A `frame_start` while `enable` is low leaves the block idle.
- R3: Pixel k of a frame (k counted from 0) sits at column k mod `src_w` and line k div `src_w`. `pix_fwd` is high in the cycle of a running pixel-valid exactly when clip_x <= column < clip_x+clip_w and clip_y <= line < clip_y+clip_h.
- R4: The cycle after the pixel at column clip_x+clip_w-1, line clip_y+clip_h-1 is accepted, status becomes end-of-frame wait. If that pixel is never forwarded, status becomes end-of-frame wait after the last source pixel (column src_w-1, line src_h-1).
- R5: In end-of-frame wait, an `eof_ack` moves status to end-of-frame done, then frame complete, then idle, one cycle each.
- R6: `pix_cnt` counts the forwarded pixels of the current frame and `line_cnt` gives the current input line. Both return to 0 in the clear phase.
- R7: Interrupt bit 0 (frame complete) sets when status becomes frame complete. Bit 1 (start dropped) sets on a `frame_start` with `enable` high while not idle. Bit 2 (soft reset done) sets when status becomes soft-reset done. A bit whose `irq_en` bit is 0 does not set.
- R8: A 1 in `irq_clr` clears the matching `irq_sta` bit on the next cycle. `irq` is high when any bit is both set and enabled.
- R9: `soft_rst` high in any state other than idle, soft-reset wait or soft-reset done moves status to soft-reset wait, then soft-reset done, then idle. Both counters clear while it is high, and idle holds while it stays high, even against a frame start.
- R10: Pixel-valid strobes outside the running state are not counted and do not move the raster position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable |
| soft_rst | input | 1 | Soft-reset request, level |
| irq_en | input | 3 | Interrupt enable mask |
| irq_clr | input | 3 | Write-one-to-clear for interrupt status |
| frame_start | input | 1 | Frame-start strobe |
| pix_valid | input | 1 | Input pixel strobe |
| eof_ack | input | 1 | End-of-frame acknowledge from memory side |
| src_w | input | COORD_W | Source width in pixels |
| src_h | input | COORD_W | Source height in lines |
| clip_x | input | COORD_W | Clip origin column |
| clip_y | input | COORD_W | Clip origin line |
| clip_w | input | COORD_W | Clip width |
| clip_h | input | COORD_W | Clip height |
| status | output | 10 | One-hot sequencer status |
| idle | output | 1 | Idle flag |
| irq_sta | output | 3 | Interrupt status bits |
| irq | output | 1 | Combined enabled interrupt |
| pix_fwd | output | 1 | Current pixel forwarded |
| line_cnt | output | CNT_W | Current input line |
| pix_cnt | output | CNT_W | Forwarded pixels this frame |

## Verification
The bench builds the block with COORD_W of 5 and CNT_W of 16 and uses a 4 by 3 source. At that size it can sweep every clip origin and every clip size that fits. This covers empty windows, single pixels, full rows, full columns and the whole frame. For each window it checks every pixel's forward decision, the exact cycle of end-of-frame wait, and the final counters against values computed from the raster arithmetic. The directed cases then cover soft reset in mid-frame, held soft reset, dropped starts, masking and clearing of interrupts, and strobes outside the running phase.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
   localparam int ST_W  = 10;
   localparam int IRQ_N = 3;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE    = 10'h001,
      ST_CLEAR   = 10'h002,
      ST_PREP_A  = 10'h004,
      ST_PREP_B  = 10'h008,
      ST_RUN     = 10'h010,
      ST_EOF_W   = 10'h020,
      ST_SRST_W  = 10'h040,
      ST_EOF_D   = 10'h080,
      ST_SRST_D  = 10'h100,
      ST_DONE    = 10'h200
   } seq_state_t;

   localparam int IRQ_FRAME = 0;
   localparam int IRQ_DROP  = 1;
   localparam int IRQ_SRST  = 2;
endpackage

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
   import wfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       soft_rst,
   input  logic       frame_start,
   input  logic       frame_end,
   input  logic       eof_ack,
   output seq_state_t state
);
   seq_state_t nxt;
   logic       in_srst_path;

   assign in_srst_path = (state == ST_IDLE) || (state == ST_SRST_W) || (state == ST_SRST_D);

   always_comb begin
      nxt = state;
      if (soft_rst && !in_srst_path) begin
         nxt = ST_SRST_W;
      end else begin
         unique case (state)
            ST_IDLE:   if (!soft_rst && enable && frame_start) nxt = ST_CLEAR;
            ST_CLEAR:  nxt = ST_PREP_A;
            ST_PREP_A: nxt = ST_PREP_B;
            ST_PREP_B: nxt = ST_RUN;
            ST_RUN:    if (frame_end) nxt = ST_EOF_W;
            ST_EOF_W:  if (eof_ack) nxt = ST_EOF_D;
            ST_EOF_D:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            ST_SRST_W: nxt = ST_SRST_D;
            ST_SRST_D: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state) == 1); // R1
   AST_PREP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CLEAR && !soft_rst) |=> (state == ST_PREP_A)); // R2
   AST_SRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !in_srst_path) |=> (state == ST_SRST_W)); // R9
   AST_SRST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SRST_W) |=> (state == ST_SRST_D)); // R9
   AST_EOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EOF_W && !eof_ack && !soft_rst) |=> (state == ST_EOF_W)); // R5
endmodule

// File: rtl/wfs_scan.sv
module wfs_scan #(
   parameter int COORD_W = 14,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               run,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] src_w,
   input  logic [COORD_W-1:0] src_h,
   input  logic [COORD_W-1:0] clip_x,
   input  logic [COORD_W-1:0] clip_y,
   input  logic [COORD_W-1:0] clip_w,
   input  logic [COORD_W-1:0] clip_h,
   output logic               pix_fwd,
   output logic               frame_end,
   output logic [CNT_W-1:0]   line_cnt,
   output logic [CNT_W-1:0]   pix_cnt
);
   localparam int EXT_W = COORD_W + 1;

   logic [COORD_W-1:0] col_q, row_q;
   logic [EXT_W-1:0]   col_nx, row_nx, clip_xe, clip_ye;
   logic               in_col, in_row, clip_last, src_last, row_wrap, step;

   generate
      if (CNT_W < COORD_W) begin : g_bad_cnt
         $error("wfs_scan: CNT_W must be at least COORD_W");
      end
   endgenerate

   assign col_nx  = {1'b0, col_q} + EXT_W'(1);
   assign row_nx  = {1'b0, row_q} + EXT_W'(1);
   assign clip_xe = {1'b0, clip_x} + {1'b0, clip_w};
   assign clip_ye = {1'b0, clip_y} + {1'b0, clip_h};

   assign in_col    = (col_q >= clip_x) && ({1'b0, col_q} < clip_xe);
   assign in_row    = (row_q >= clip_y) && ({1'b0, row_q} < clip_ye);
   assign step      = run && pix_valid;
   assign pix_fwd   = step && in_col && in_row;
   assign row_wrap  = (col_nx >= {1'b0, src_w});
   assign clip_last = (col_nx == clip_xe) && (row_nx == clip_ye);
   assign src_last  = row_wrap && (row_nx >= {1'b0, src_h});
   assign frame_end = step && ((pix_fwd && clip_last) || src_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q   <= '0;
         row_q   <= '0;
         pix_cnt <= '0;
      end else if (clr) begin
         col_q   <= '0;
         row_q   <= '0;
         pix_cnt <= '0;
      end else if (step) begin
         if (row_wrap) begin
            col_q <= '0;
            row_q <= row_q + COORD_W'(1);
         end else begin
            col_q <= col_q + COORD_W'(1);
         end
         if (pix_fwd) pix_cnt <= pix_cnt + CNT_W'(1);
      end
   end

   assign line_cnt = CNT_W'(row_q);

   AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(pix_cnt)); // R10
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pix_cnt == '0 && line_cnt == '0)); // R6
   AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pix_fwd |-> (run && pix_valid)); // R3
endmodule

// File: rtl/wfs_irq.sv
module wfs_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   input  logic [N-1:0] clr,
   output logic [N-1:0] sta,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sta[i] <= 1'b0;
            else        sta[i] <= (sta[i] & ~clr[i]) | (ev[i] & en[i]);
         end

         AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !sta[i]) |=> !sta[i]); // R7
         AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !(ev[i] && en[i])) |=> !sta[i]); // R8
      end
   endgenerate

   assign irq = |(sta & en);
endmodule

// File: rtl/wdma_frame_seq.sv
module wdma_frame_seq
   import wfs_pkg::*;
#(
   parameter int COORD_W = 14,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               soft_rst,
   input  logic [2:0]         irq_en,
   input  logic [2:0]         irq_clr,
   input  logic               frame_start,
   input  logic               pix_valid,
   input  logic               eof_ack,
   input  logic [COORD_W-1:0] src_w,
   input  logic [COORD_W-1:0] src_h,
   input  logic [COORD_W-1:0] clip_x,
   input  logic [COORD_W-1:0] clip_y,
   input  logic [COORD_W-1:0] clip_w,
   input  logic [COORD_W-1:0] clip_h,
   output logic [9:0]         status,
   output logic               idle,
   output logic [2:0]         irq_sta,
   output logic               irq,
   output logic               pix_fwd,
   output logic [CNT_W-1:0]   line_cnt,
   output logic [CNT_W-1:0]   pix_cnt
);
   seq_state_t         state;
   logic               frame_end;
   logic [IRQ_N-1:0]   ev;

   generate
      if (COORD_W < 2 || COORD_W > 16) begin : g_bad_coord
         $error("wdma_frame_seq: COORD_W out of range");
      end
   endgenerate

   wfs_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .soft_rst    (soft_rst),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .eof_ack     (eof_ack),
      .state       (state)
   );

   wfs_scan #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst || (state == ST_CLEAR)),
      .run       (state == ST_RUN),
      .pix_valid (pix_valid),
      .src_w     (src_w),
      .src_h     (src_h),
      .clip_x    (clip_x),
      .clip_y    (clip_y),
      .clip_w    (clip_w),
      .clip_h    (clip_h),
      .pix_fwd   (pix_fwd),
      .frame_end (frame_end),
      .line_cnt  (line_cnt),
      .pix_cnt   (pix_cnt)
   );

   always_comb begin
      ev            = '0;
      ev[IRQ_FRAME] = (state == ST_EOF_D) && !soft_rst;
      ev[IRQ_DROP]  = frame_start && enable && (state != ST_IDLE);
      ev[IRQ_SRST]  = (state == ST_SRST_W);
   end

   wfs_irq #(.N(IRQ_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .en    (irq_en),
      .clr   (irq_clr),
      .sta   (irq_sta),
      .irq   (irq)
   );

   assign status = state;
   assign idle   = (state == ST_IDLE);

   AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EOF_D && !soft_rst && irq_en[0]) |=> irq_sta[0]); // R7
   AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && soft_rst) |=> idle); // R9
endmodule

// File: tb/tb_wdma_frame_seq.sv
module tb_wdma_frame_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 5;
   localparam int NW = 16;
   localparam int SW = 4;
   localparam int SH = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, soft_rst = 0, frame_start = 0, pix_valid = 0, eof_ack = 0;
   logic [2:0] irq_en = 0, irq_clr = 0;
   logic [CW-1:0] src_w = SW, src_h = SH, clip_x = 0, clip_y = 0, clip_w = 0, clip_h = 0;
   logic [9:0] status;
   logic idle, irq, pix_fwd;
   logic [2:0] irq_sta;
   logic [NW-1:0] line_cnt, pix_cnt;

   int n_chk = 0, n_err = 0, cycles = 0;

   wdma_frame_seq #(.COORD_W(CW), .CNT_W(NW)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
      .irq_en(irq_en), .irq_clr(irq_clr), .frame_start(frame_start),
      .pix_valid(pix_valid), .eof_ack(eof_ack), .src_w(src_w), .src_h(src_h),
      .clip_x(clip_x), .clip_y(clip_y), .clip_w(clip_w), .clip_h(clip_h),
      .status(status), .idle(idle), .irq_sta(irq_sta), .irq(irq),
      .pix_fwd(pix_fwd), .line_cnt(line_cnt), .pix_cnt(pix_cnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic start_frame(input bit pv_during_prep);
      frame_start = 1; tick(); frame_start = 0;
      pix_valid = pv_during_prep;
      chk("R2 clear", status, 10'h002);
      tick(); chk("R2 prepA", status, 10'h004);
      tick(); chk("R2 prepB", status, 10'h008);
      tick(); chk("R2 run", status, 10'h010);
      pix_valid = 0;
   endtask

   function automatic bit inside_clip(int k, int cx, int cy, int cwid, int chgt);
      int x = k % SW;
      int y = k / SW;
      return (x >= cx) && (x < cx + cwid) && (y >= cy) && (y < cy + chgt);
   endfunction

   task automatic run_window(int cx, int cy, int cwid, int chgt);
      int n_pix, acc;
      clip_x = cx; clip_y = cy; clip_w = cwid; clip_h = chgt;
      if (cwid > 0 && chgt > 0) n_pix = (cy + chgt - 1) * SW + cx + cwid;
      else n_pix = SW * SH;
      acc = 0;
      start_frame(0);
      for (int k = 0; k < n_pix; k++) begin
         chk("R4 not ended early", status, 10'h010);
         pix_valid = 1; #1;
         chk("R3 forward", pix_fwd, inside_clip(k, cx, cy, cwid, chgt));
         if (inside_clip(k, cx, cy, cwid, chgt)) acc++;
         tick();
      end
      pix_valid = 0;
      chk("R4 eof wait", status, 10'h020);
      chk("R6 pix_cnt", pix_cnt, acc);
      chk("R6 line_cnt", line_cnt, n_pix / SW);
      tick(); chk("R5 wait holds", status, 10'h020);
      eof_ack = 1; tick(); eof_ack = 0;
      chk("R5 eof done", status, 10'h080);
      tick(); chk("R5 complete", status, 10'h200);
      chk("R7 frame irq", irq_sta[0], 1'b1);
      tick(); chk("R5 idle", status, 10'h001);
      chk("R1 idle flag", idle, 1'b1);
      irq_clr = 3'b001; tick(); irq_clr = 0;
      chk("R8 cleared", irq_sta, 3'b000);
   endtask

   initial begin
      tick(); tick();
      chk("R1 reset status", status, 10'h001);
      chk("R1 reset idle", idle, 1'b1);
      chk("R1 reset irq", irq_sta, 3'b000);
      chk("R6 reset cnt", pix_cnt, 0);
      rst_n = 1; tick();

      // R2: start ignored while disabled
      frame_start = 1; tick(); frame_start = 0;
      chk("R2 disabled start", status, 10'h001);

      enable = 1; irq_en = 3'b111;
      for (int cx = 0; cx < SW; cx++)
         for (int cwid = 0; cwid <= SW - cx; cwid++)
            for (int cy = 0; cy < SH; cy++)
               for (int chgt = 0; chgt <= SH - cy; chgt++)
                  run_window(cx, cy, cwid, chgt);

      // R10: strobes outside run ignored
      clip_x = 0; clip_y = 0; clip_w = SW; clip_h = SH;
      start_frame(1);
      chk("R10 no count in prep", pix_cnt, 0);
      chk("R10 no line in prep", line_cnt, 0);
      pix_valid = 1; #1; chk("R10 first pixel at col0", pix_fwd, 1'b1);
      tick(); pix_valid = 0;
      chk("R6 one accepted", pix_cnt, 1);

      // R7: dropped start while running
      frame_start = 1; tick(); frame_start = 0;
      chk("R7 drop status", status, 10'h010);
      chk("R7 drop irq", irq_sta, 3'b010);
      chk("R8 irq out", irq, 1'b1);
      irq_clr = 3'b010; tick(); irq_clr = 0;
      chk("R8 drop cleared", irq_sta, 3'b000);

      // R9: soft reset mid-frame
      for (int k = 0; k < 5; k++) begin pix_valid = 1; tick(); end
      pix_valid = 0;
      chk("R6 mid count", pix_cnt, 6);
      chk("R6 mid line", line_cnt, 1);
      soft_rst = 1; tick();
      chk("R9 srst wait", status, 10'h040);
      chk("R9 cnt cleared", pix_cnt, 0);
      chk("R9 line cleared", line_cnt, 0);
      tick(); chk("R9 srst done", status, 10'h100);
      chk("R7 srst irq", irq_sta, 3'b100);
      tick(); chk("R9 idle", status, 10'h001);
      frame_start = 1; tick(); frame_start = 0;
      chk("R9 held idle", status, 10'h001);
      soft_rst = 0;
      irq_clr = 3'b100; tick(); irq_clr = 0;
      chk("R8 srst cleared", irq_sta, 3'b000);

      // R7: masked frame-complete does not set
      irq_en = 3'b110;
      clip_x = 1; clip_y = 1; clip_w = 1; clip_h = 1;
      start_frame(0);
      for (int k = 0; k < SW + 2; k++) begin pix_valid = 1; tick(); end
      pix_valid = 0;
      chk("R4 single pixel end", status, 10'h020);
      chk("R6 single pixel count", pix_cnt, 1);
      eof_ack = 1; tick(); eof_ack = 0; tick();
      chk("R5 complete masked", status, 10'h200);
      chk("R7 masked no set", irq_sta, 3'b000);
      chk("R8 irq low", irq, 1'b0);
      tick(); chk("R5 back idle", idle, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule